// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block holds the 8-bit control and status register through which firmware starts flash self-programming operations. Firmware writes a command bit together with the enable bit. That write arms the command for a short window. A store-program strobe inside the window starts the command. If no strobe comes, the command is dropped. The block decodes the armed command into one-cycle requests toward the flash: page erase, page write, page-buffer load or lock-bit write. It also handles the re-enable of the read-while-write section.

The block tracks a busy flag for the read-while-write section and blocks reads of that section while the flag is set. The flag has two clearing paths: a re-enable command, or a page-buffer load. The block requests a page-buffer clear when a load in progress is aborted or when the section is re-enabled. While the lock-bit command is armed, a load-program strobe returns a configuration read, and the pointer low bit chooses lock bits or fuse bits. A ready interrupt is raised whenever the enable bit is clear and both interrupt enables are set. The flash array, the page-buffer storage and the lock and fuse contents are outside this block.

Top module: `selfProgCtl`

## Requirements
- R1: The register reads as bit 7 interrupt enable, bit 6 section busy, bit 5 zero, bit 4 section re-enable, bit 3 lock-bit set, bit 2 page write, bit 1 page erase, bit 0 enable. After reset, the register and every output are zero.
- R2: Writes to bit 6 and bit 5 have no effect. Bit 5 always reads 0.
- R3: A register write with bit 0 = 1 loads bits 4..0 and arms the command. A write with bit 0 = 0 clears bits 4..0. A store strobe in any of the four cycles after the arming write executes the command. When several command bits are set, the order of precedence is lock-bit set, then page write, then page erase, then re-enable, then page load (enable alone).
- R4: If no store strobe arrives in the four cycles after arming, bits 4..0 read zero from the cycle after the fourth, and a later strobe does nothing.
- R5: A page erase or page write strobe gives a one-cycle eraseReq or writeReq pulse in the next cycle. In that same cycle rwwBusy and rwwReadBlock rise. Bits 4..0 stay set until flashDone, and they read zero in the cycle after it.
- R6: While an erase, write or lock-bit operation is in progress, register writes leave bits 4..0 unchanged. A re-enable command written then is therefore ignored. Bit 7 is still written.
- R7: A re-enable strobe clears the busy flag, pulses pageBufClear and clears bits 4..0. A page-load strobe (enable alone) pulses pageLoadReq, clears the busy flag and clears bits 4..0.
- R8: A register write with bit 4 = 1 after a page load, and before the next erase, write or re-enable, aborts the load. It pulses pageBufClear in the next cycle.
- R9: A lock-bit strobe pulses lockWrReq. The command bits stay set until flashDone and clear in the cycle after it.
- R10: A load strobe in any of the first three cycles after arming lock-bit set gives a one-cycle cfgRdValid pulse in the next cycle. cfgRdSel then equals the pointer bit (0 = lock bits, 1 = fuse bits). A load strobe in the fourth cycle gives no pulse.
- R11: readyIrq equals bit 7 AND globalIntEn AND NOT bit 0 in every cycle.
- R12: flashDone has no effect when no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| storeStrobe | input | 1 | Store-program instruction executed |
| loadStrobe | input | 1 | Load-program instruction executed |
| ptrLsb | input | 1 | Pointer bit 0 for configuration reads |
| globalIntEn | input | 1 | Global interrupt enable |
| flashDone | input | 1 | Flash reports the current operation complete |
| eraseReq | output | 1 | One-cycle page erase request |
| writeReq | output | 1 | One-cycle page write request |
| lockWrReq | output | 1 | One-cycle lock-bit write request |
| pageLoadReq | output | 1 | One-cycle page-buffer load request |
| pageBufClear | output | 1 | One-cycle page-buffer clear request |
| cfgRdValid | output | 1 | One-cycle configuration read request |
| cfgRdSel | output | 1 | Configuration read select: 0 lock, 1 fuse |
| rwwBusy | output | 1 | Read-while-write section busy |
| rwwReadBlock | output | 1 | Reads of the read-while-write section blocked |
| readyIrq | output | 1 | Ready interrupt |

## Verification
Wrong internal state here has three main symptoms. A window counter that is off by one moves the last accepted strobe by a cycle. A missed in-progress marker lets a re-enable or a new command through during an erase. A stale loading marker produces a spurious page-buffer clear or misses a real one. Each of these shows on the request pulses or the register read data within one cycle of the stimulus that exposes it. The busy flag and the command bits are visible on regRdData in every cycle, so a corrupted flag is seen at the next comparison.

// File: rtl/selfProgPkg.sv
package selfProgPkg;
  localparam int REG_W     = 8;
  localparam int CMD_W     = 5;
  localparam int BIT_IRQ   = 7;
  localparam int BIT_BUSY  = 6;
  localparam int BIT_RSV   = 5;
  localparam int BIT_REEN  = 4;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_WRITE = 2;
  localparam int BIT_ERASE = 1;
  localparam int BIT_EN    = 0;

  typedef struct packed {
    logic irqLoad;
    logic cmdLoad;
    logic clearCmd;
    logic execLoad;
    logic execErase;
    logic execWrite;
    logic execLock;
    logic execReEnable;
    logic abortLoad;
    logic cfgRead;
  } ctlStrobes_t;
endpackage

// File: rtl/spCtl.sv
module spCtl
  import selfProgPkg::*;
#(
  parameter int WIN_CYCLES = 4,
  parameter int CFG_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               storeStrobe,
  input  logic               loadStrobe,
  input  logic               flashDone,
  input  logic [CMD_W-1:0]   cmdBits,
  input  logic               loading,
  output ctlStrobes_t        st
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] CFG_FLOOR = CW'(WIN_CYCLES - CFG_CYCLES);

  logic [CW-1:0] winCnt;
  logic          opActive;
  logic          armed, idleArmed, fire, finish, wrCmd, expire;
  logic          hiCmd;

  always_comb begin
    armed     = cmdBits[BIT_EN] & ~opActive;
    idleArmed = armed & ~regWrEn;
    fire      = idleArmed & storeStrobe;
    finish    = opActive & flashDone;
    wrCmd     = regWrEn & ~opActive;
    expire    = idleArmed & ~storeStrobe & (winCnt == CW'(1));
    hiCmd     = cmdBits[BIT_LOCK] | cmdBits[BIT_WRITE] | cmdBits[BIT_ERASE];

    st.irqLoad      = regWrEn;
    st.cmdLoad      = wrCmd;
    st.execLock     = fire & cmdBits[BIT_LOCK];
    st.execWrite    = fire & ~cmdBits[BIT_LOCK] & cmdBits[BIT_WRITE];
    st.execErase    = fire & ~cmdBits[BIT_LOCK] & ~cmdBits[BIT_WRITE] & cmdBits[BIT_ERASE];
    st.execReEnable = fire & ~hiCmd & cmdBits[BIT_REEN];
    st.execLoad     = fire & ~hiCmd & ~cmdBits[BIT_REEN];
    st.clearCmd     = finish | expire | st.execReEnable | st.execLoad;
    st.abortLoad    = wrCmd & regWrData[BIT_REEN] & loading;
    st.cfgRead      = idleArmed & ~storeStrobe & loadStrobe & cmdBits[BIT_LOCK]
                      & (winCnt > CFG_FLOOR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opActive <= 1'b0;
    end else if (finish) begin
      opActive <= 1'b0;
    end else if (st.execLock | st.execWrite | st.execErase) begin
      opActive <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (wrCmd & regWrData[BIT_EN]) begin
      winCnt <= WIN_LOAD;
    end else if (idleArmed & ~storeStrobe & (winCnt != '0)) begin
      winCnt <= winCnt - CW'(1);
    end
  end
endmodule

// File: rtl/spDatapath.sv
module spDatapath
  import selfProgPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        st,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               ptrLsb,
  input  logic               globalIntEn,
  output logic [CMD_W-1:0]   cmdBits,
  output logic               loading,
  output logic [REG_W-1:0]   regRdData,
  output logic               rwwBusy,
  output logic               rwwReadBlock,
  output logic               eraseReq,
  output logic               writeReq,
  output logic               lockWrReq,
  output logic               pageLoadReq,
  output logic               pageBufClear,
  output logic               cfgRdValid,
  output logic               cfgRdSel,
  output logic               readyIrq
);
  localparam int NPULSE = 6;

  logic              irqEn, busy;
  logic [NPULSE-1:0] pulseNext, pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqEn <= 1'b0;
    else if (st.irqLoad) irqEn <= regWrData[BIT_IRQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= '0;
    end else if (st.cmdLoad) begin
      cmdBits <= regWrData[BIT_EN] ? regWrData[CMD_W-1:0] : '0;
    end else if (st.clearCmd) begin
      cmdBits <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else if (st.execErase | st.execWrite) busy <= 1'b1;
    else if (st.execReEnable | st.execLoad) busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loading <= 1'b0;
    else if (st.execLoad) loading <= 1'b1;
    else if (st.execErase | st.execWrite | st.execReEnable | st.abortLoad) loading <= 1'b0;
  end

  assign pulseNext = {st.cfgRead, st.execReEnable | st.abortLoad, st.execLoad,
                      st.execLock, st.execWrite, st.execErase};

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ[i] <= 1'b0;
      else pulseQ[i] <= pulseNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgRdSel <= 1'b0;
    else if (st.cfgRead) cfgRdSel <= ptrLsb;
  end

  assign eraseReq     = pulseQ[0];
  assign writeReq     = pulseQ[1];
  assign lockWrReq    = pulseQ[2];
  assign pageLoadReq  = pulseQ[3];
  assign pageBufClear = pulseQ[4];
  assign cfgRdValid   = pulseQ[5];

  assign rwwBusy      = busy;
  assign rwwReadBlock = busy;
  assign regRdData    = {irqEn, busy, 1'b0, cmdBits};
  assign readyIrq     = irqEn & globalIntEn & ~cmdBits[BIT_EN];
endmodule

// File: rtl/selfProgCtl.sv
module selfProgCtl
  import selfProgPkg::*;
#(
  parameter int WIN_CYCLES = 4,
  parameter int CFG_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             storeStrobe,
  input  logic             loadStrobe,
  input  logic             ptrLsb,
  input  logic             globalIntEn,
  input  logic             flashDone,
  output logic             eraseReq,
  output logic             writeReq,
  output logic             lockWrReq,
  output logic             pageLoadReq,
  output logic             pageBufClear,
  output logic             cfgRdValid,
  output logic             cfgRdSel,
  output logic             rwwBusy,
  output logic             rwwReadBlock,
  output logic             readyIrq
);
  ctlStrobes_t      st;
  logic [CMD_W-1:0] cmdBits;
  logic             loading;

  spCtl #(.WIN_CYCLES(WIN_CYCLES), .CFG_CYCLES(CFG_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe), .flashDone(flashDone),
    .cmdBits(cmdBits), .loading(loading), .st(st)
  );

  spDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .regWrData(regWrData), .ptrLsb(ptrLsb),
    .globalIntEn(globalIntEn), .cmdBits(cmdBits), .loading(loading),
    .regRdData(regRdData), .rwwBusy(rwwBusy), .rwwReadBlock(rwwReadBlock),
    .eraseReq(eraseReq), .writeReq(writeReq), .lockWrReq(lockWrReq),
    .pageLoadReq(pageLoadReq), .pageBufClear(pageBufClear),
    .cfgRdValid(cfgRdValid), .cfgRdSel(cfgRdSel), .readyIrq(readyIrq)
  );
endmodule

// File: rtl/selfProgChk.sv
module selfProgChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       globalIntEn,
  input logic       eraseReq,
  input logic       writeReq,
  input logic       lockWrReq,
  input logic       pageLoadReq,
  input logic       cfgRdValid,
  input logic       rwwBusy,
  input logic       rwwReadBlock,
  input logic       readyIrq
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[5] == 1'b0);

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyIrq == (regRdData[7] & globalIntEn & ~regRdData[0]));

  // R3
  one_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseReq, writeReq, lockWrReq, pageLoadReq}));

  // R5
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq | writeReq) |-> (rwwBusy && rwwReadBlock && regRdData[0]));

  // R5
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    rwwBusy == regRdData[6]);

  // R7
  load_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageLoadReq |-> (!rwwBusy && regRdData[4:0] == 5'd0));

  // R10
  cfg_under_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> regRdData[3]);
endmodule

bind selfProgCtl selfProgChk u_chk (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .globalIntEn(globalIntEn),
  .eraseReq(eraseReq), .writeReq(writeReq), .lockWrReq(lockWrReq),
  .pageLoadReq(pageLoadReq), .cfgRdValid(cfgRdValid), .rwwBusy(rwwBusy),
  .rwwReadBlock(rwwReadBlock), .readyIrq(readyIrq)
);

// File: tb/selfProgCtl_tb.sv
module selfProgCtl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       storeStrobe = 1'b0, loadStrobe = 1'b0, ptrLsb = 1'b0;
  logic       globalIntEn = 1'b0, flashDone = 1'b0;
  logic [7:0] regRdData;
  logic eraseReq, writeReq, lockWrReq, pageLoadReq, pageBufClear;
  logic cfgRdValid, cfgRdSel, rwwBusy, rwwReadBlock, readyIrq;

  int    vectors = 0;
  int    errs = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #5 clk = ~clk;

  selfProgCtl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .storeStrobe(storeStrobe), .loadStrobe(loadStrobe),
    .ptrLsb(ptrLsb), .globalIntEn(globalIntEn), .flashDone(flashDone),
    .eraseReq(eraseReq), .writeReq(writeReq), .lockWrReq(lockWrReq),
    .pageLoadReq(pageLoadReq), .pageBufClear(pageBufClear),
    .cfgRdValid(cfgRdValid), .cfgRdSel(cfgRdSel), .rwwBusy(rwwBusy),
    .rwwReadBlock(rwwReadBlock), .readyIrq(readyIrq)
  );

  // Behavioural reference model
  logic       mIrq, mBusy, mOp, mLoad, mSel;
  logic [4:0] mCmd;
  int         mWin;
  logic       pErase, pWrite, pLock, pLd, pBuf, pCfg;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIrq = 0; mBusy = 0; mOp = 0; mLoad = 0; mSel = 0; mCmd = 0; mWin = 0;
      pErase = 0; pWrite = 0; pLock = 0; pLd = 0; pBuf = 0; pCfg = 0;
    end else begin
      pErase = 0; pWrite = 0; pLock = 0; pLd = 0; pBuf = 0; pCfg = 0;
      if (regWrEn) mIrq = regWrData[7];
      if (mOp) begin
        if (flashDone) begin mOp = 0; mCmd = 0; end
      end else if (regWrEn) begin
        if (regWrData[4] && mLoad) begin mLoad = 0; pBuf = 1; end
        mCmd = regWrData[0] ? regWrData[4:0] : 5'd0;
        mWin = 4;
      end else if (mCmd[0]) begin
        if (storeStrobe) begin
          if (mCmd[3]) begin pLock = 1; mOp = 1; end
          else if (mCmd[2]) begin pWrite = 1; mOp = 1; mBusy = 1; mLoad = 0; end
          else if (mCmd[1]) begin pErase = 1; mOp = 1; mBusy = 1; mLoad = 0; end
          else if (mCmd[4]) begin pBuf = 1; mBusy = 0; mLoad = 0; mCmd = 0; end
          else begin pLd = 1; mBusy = 0; mLoad = 1; mCmd = 0; end
        end else begin
          if (loadStrobe && mCmd[3] && mWin >= 2) begin pCfg = 1; mSel = ptrLsb; end
          if (mWin == 1) mCmd = 0;
          else mWin = mWin - 1;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("regRdData", regRdData, {mIrq, mBusy, 1'b0, mCmd});
    chk("rwwBusy", {7'd0, rwwBusy}, {7'd0, mBusy});
    chk("rwwReadBlock", {7'd0, rwwReadBlock}, {7'd0, mBusy});
    chk("eraseReq", {7'd0, eraseReq}, {7'd0, pErase});
    chk("writeReq", {7'd0, writeReq}, {7'd0, pWrite});
    chk("lockWrReq", {7'd0, lockWrReq}, {7'd0, pLock});
    chk("pageLoadReq", {7'd0, pageLoadReq}, {7'd0, pLd});
    chk("pageBufClear", {7'd0, pageBufClear}, {7'd0, pBuf});
    chk("cfgRdValid", {7'd0, cfgRdValid}, {7'd0, pCfg});
    chk("cfgRdSel", {7'd0, cfgRdSel}, {7'd0, mSel});
    chk("readyIrq", {7'd0, readyIrq}, {7'd0, mIrq & globalIntEn & ~mCmd[0]});
  end

  // One cycle of stimulus, driven just after the rising edge
  task automatic step(input bit wr, input logic [7:0] d, input bit stS,
                      input bit ldS, input bit ptr, input bit dn);
    regWrEn = wr; regWrData = d; storeStrobe = stS; loadStrobe = ldS;
    ptrLsb = ptr; flashDone = dn;
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1, d, 0, 0, 0, 0);
  endtask

  task automatic strobe();
    step(0, 8'h00, 1, 0, 0, 0);
  endtask

  task automatic finishOp();
    step(0, 8'h00, 0, 0, 0, 1);
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle(2);

    curReq = "R11"; globalIntEn = 1'b1; wr(8'h80); idle(2);
    globalIntEn = 1'b0; idle(1); globalIntEn = 1'b1; idle(1);

    curReq = "R2"; wr(8'hE0); idle(2);

    curReq = "R5"; wr(8'h83); idle(1); strobe(); idle(3);
    curReq = "R6"; wr(8'h11); idle(1); wr(8'h03); idle(1); strobe(); idle(1);
    curReq = "R5"; finishOp(); idle(2);

    curReq = "R7"; wr(8'h91); strobe(); idle(2);

    curReq = "R4"; wr(8'h05); idle(6); strobe(); idle(2);
    curReq = "R3"; wr(8'h05); idle(3); strobe(); idle(2); finishOp(); idle(1);
    curReq = "R4"; wr(8'h03); idle(4); strobe(); idle(2);

    curReq = "R12"; finishOp(); idle(1);

    curReq = "R7"; wr(8'h01); strobe(); idle(2);
    curReq = "R8"; wr(8'h10); idle(1); wr(8'h11); strobe(); idle(2);
    curReq = "R8"; wr(8'h01); strobe(); idle(1); wr(8'h11); strobe(); idle(2);

    curReq = "R10"; wr(8'h09);
    step(0, 8'h00, 0, 1, 1, 0);
    step(0, 8'h00, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0);
    idle(2);
    curReq = "R9"; wr(8'h09); idle(3); strobe(); idle(2); finishOp(); idle(2);

    curReq = "R3"; wr(8'h1F); strobe(); idle(1); finishOp(); idle(1);
    wr(8'h17); strobe(); idle(1); finishOp(); idle(1);
    wr(8'h13); strobe(); idle(1); finishOp(); idle(1);
    wr(8'h11); strobe(); idle(2);
    wr(8'h1E); idle(1); strobe(); idle(2);

    curReq = "R11"; wr(8'h81); idle(1); globalIntEn = 1'b0; idle(6); globalIntEn = 1'b1; idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule